// File: doc/BRIEF.md
# DRAM refresh and initialization scheduler

This block keeps an asynchronous DRAM alive without help from the access path. After reset it waits out the power-up pause. It then runs a fixed number of wake-up cycles. After that it owes one refresh per refresh interval, so that 4096 rows are covered inside the 64 ms retention window. Each refresh is a CAS-before-RAS cycle, in which the memory picks the row itself, so the scheduler never drives an address or data.

The block shares the strobe bus with an access sequencer through a request/grant pair. `ref_req` rises while a cycle is owed. The sequence starts once a grant is seen, and the strobes run a fixed setup / RAS-low / precharge pattern. A backlog counter lets up to `MAX_PEND` refreshes wait while the access side is busy. One more owed refresh counts as a missed deadline. That raises a sticky error and repeats the wake-up cycles before `init_done` returns. Every interval is given in nanoseconds and turned into clock cycles at elaboration.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied and on the first cycle after it, all three strobes are high (inactive), and `ref_req`, `init_done` and `err_flag` are low.
- R2: For the first PAUSE cycles after reset is released, `ref_req` stays low and no strobe goes low.
- R3: After the pause, exactly WAKE_CYCLES CAS-before-RAS cycles are run. `init_done` then rises in the cycle after the last of them ends its precharge.
- R4: In every cycle issued, both CAS strobes are low for exactly CSR cycles before RAS falls. They stay low for exactly CHR cycles after RAS falls, and they rise while RAS is still low.
- R5: RAS stays low for exactly RASW cycles (at least CHR+1). RAS and CAS then both stay high for at least PRE cycles, the larger of the RAS precharge and RAS-to-CAS precharge, before CAS falls again.
- R6: Once initialized with the grant held high, one refresh is owed every REFI cycles, so RAS falls exactly REFI cycles apart.
- R7: While no grant is seen, the strobes stay high even when `ref_req` is high. A sequence starts on the first clock edge where `ref_req` and `ref_gnt` are both high, with the CAS strobes low from the next cycle. Once started, the sequence runs to the end whatever `ref_gnt` does, with `ref_req` held high until its precharge ends.
- R8: Up to MAX_PEND owed refreshes may wait without error. When the grant returns they are issued back to back, one idle cycle apart.
- R9: A refresh interval ending with MAX_PEND already owed and none completing in that cycle sets `err_flag`, which stays set until reset. It also drops `init_done` and reruns WAKE_CYCLES wake-up cycles with no pause, after which `init_done` rises again.
- R10: Each interval in cycles is the nanosecond parameter divided by the clock period, rounded up, with a minimum of 1.
- R11: The lower and upper CAS strobes always carry the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_gnt | input | 1 | Grant of the strobe bus from the access sequencer |
| ref_req | output | 1 | Bus wanted or owned for a refresh or wake-up cycle |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| init_done | output | 1 | Wake-up complete, normal accesses allowed |
| err_flag | output | 1 | Sticky missed-deadline flag |

## Verification
The checker assumes only that `ref_gnt` is a clean level sampled at the clock edge. It assumes that the intervals given satisfy PAUSE ≥ PRE, so the first CAS fall after reset meets the precharge window, and it places no limit on how the grant behaves during a sequence. The stimulus drives the grant only on the falling clock edge. It holds the grant high through initialization, withholds it for stretches short and long enough to fill and overflow the backlog, and then toggles it from a pseudo-random sequence, including in the middle of sequences, which the block must ignore.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_WAKE,
        PH_RUN
    } phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_ACT,
        SQ_PRE
    } seq_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refsched_cbr_seq.sv
module refsched_cbr_seq
    import refsched_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int CHR_CYC = 1,
    parameter int RAS_CYC = 2,
    parameter int PRE_CYC = 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output strobe_t strb,
    output logic    busy,
    output logic    done
);
    localparam int MAXC = imax(imax(CSR_CYC, CHR_CYC), imax(RAS_CYC, PRE_CYC));
    localparam int CW   = $clog2(MAXC + 1);

    seq_e          st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SQ_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        st  <= SQ_SETUP;
                        cnt <= '0;
                    end
                end
                SQ_SETUP: begin
                    if (cnt == CW'(CSR_CYC - 1)) begin
                        st  <= SQ_ACT;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_ACT: begin
                    if (cnt == CW'(RAS_CYC - 1)) begin
                        st  <= SQ_PRE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == CW'(PRE_CYC - 1)) begin
                        st  <= SQ_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        strb.ras_n = (st != SQ_ACT);
        strb.cas_n = !((st == SQ_SETUP) || ((st == SQ_ACT) && (cnt < CW'(CHR_CYC))));
        busy       = (st != SQ_IDLE);
        done       = (st == SQ_PRE) && (cnt == CW'(PRE_CYC - 1));
    end

endmodule

// File: rtl/refsched_backlog.sv
module refsched_backlog
    import refsched_pkg::*;
#(
    parameter int REFI_CYC = 1560,
    parameter int MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic done,
    output logic owed,
    output logic ovf
);
    localparam int TW = $clog2(REFI_CYC + 1);
    localparam int PW = $clog2(MAX_PEND + 2);

    logic [TW-1:0] tcnt;
    logic [PW-1:0] pend;
    logic          tick;

    always_comb begin
        tick = run && (tcnt == TW'(REFI_CYC - 1));
        ovf  = tick && !done && (pend == PW'(MAX_PEND));
        owed = (pend != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tcnt <= '0;
            pend <= '0;
        end else begin
            tcnt <= tick ? '0 : tcnt + 1'b1;
            if (ovf) begin
                pend <= '0;
            end else if (tick && !done) begin
                pend <= pend + 1'b1;
            end else if (done && !tick && owed) begin
                pend <= pend - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import refsched_pkg::*;
#(
    parameter int CLK_PS      = 10000,
    parameter int PAUSE_NS    = 200000,
    parameter int REFI_NS     = 15600,
    parameter int CSR_NS      = 10,
    parameter int CHR_NS      = 10,
    parameter int RAS_NS      = 60,
    parameter int RP_NS       = 40,
    parameter int RPC_NS      = 5,
    parameter int WAKE_CYCLES = 8,
    parameter int MAX_PEND    = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ras_n,
    output logic lcas_n,
    output logic ucas_n,
    output logic init_done,
    output logic err_flag
);
    localparam int PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_PS);
    localparam int REFI_CYC  = ns_to_cyc(REFI_NS, CLK_PS);
    localparam int CSR_CYC   = ns_to_cyc(CSR_NS, CLK_PS);
    localparam int CHR_CYC   = ns_to_cyc(CHR_NS, CLK_PS);
    localparam int RAS_CYC   = imax(ns_to_cyc(RAS_NS, CLK_PS), CHR_CYC + 1);
    localparam int PRE_CYC   = imax(ns_to_cyc(RP_NS, CLK_PS), ns_to_cyc(RPC_NS, CLK_PS));
    localparam int PCW       = $clog2(PAUSE_CYC + 1);
    localparam int WW        = $clog2(WAKE_CYCLES + 1);

    phase_e         ph;
    logic [PCW-1:0] pcnt;
    logic [WW-1:0]  wake_left;
    logic           err_q;
    logic           work, start, busy, seq_done, owed, ovf;
    strobe_t        strb;

    refsched_cbr_seq #(
        .CSR_CYC(CSR_CYC),
        .CHR_CYC(CHR_CYC),
        .RAS_CYC(RAS_CYC),
        .PRE_CYC(PRE_CYC)
    ) u_seq (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .strb (strb),
        .busy (busy),
        .done (seq_done)
    );

    refsched_backlog #(
        .REFI_CYC(REFI_CYC),
        .MAX_PEND(MAX_PEND)
    ) u_backlog (
        .clk (clk),
        .rst (rst),
        .run (ph == PH_RUN),
        .done(seq_done),
        .owed(owed),
        .ovf (ovf)
    );

    always_comb begin
        work  = ((ph == PH_WAKE) && (wake_left != '0)) || ((ph == PH_RUN) && owed);
        start = work && ref_gnt && !busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_PAUSE;
            pcnt      <= '0;
            wake_left <= '0;
            err_q     <= 1'b0;
        end else begin
            case (ph)
                PH_PAUSE: begin
                    if (pcnt == PCW'(PAUSE_CYC - 1)) begin
                        ph        <= PH_WAKE;
                        wake_left <= WW'(WAKE_CYCLES);
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                PH_WAKE: begin
                    // wake-ups are counted as they start, so a cycle already
                    // in flight when re-initialization begins does not count
                    if (start) begin
                        wake_left <= wake_left - 1'b1;
                    end else if (seq_done && (wake_left == '0)) begin
                        ph <= PH_RUN;
                    end
                end
                default: begin
                    if (ovf) begin
                        ph        <= PH_WAKE;
                        wake_left <= WW'(WAKE_CYCLES);
                        err_q     <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign ref_req   = busy || work;
    assign ras_n     = strb.ras_n;
    assign lcas_n    = strb.cas_n;
    assign ucas_n    = strb.cas_n;
    assign init_done = (ph == PH_RUN);
    assign err_flag  = err_q;

endmodule

// File: rtl/refsched_chk.sv
module refsched_chk #(
    parameter int CSR_CYC     = 1,
    parameter int CHR_CYC     = 1,
    parameter int RAS_CYC     = 2,
    parameter int PRE_CYC     = 1,
    parameter int PAUSE_CYC   = 1,
    parameter int WAKE_CYCLES = 8
) (
    input logic clk,
    input logic rst,
    input logic ref_req,
    input logic ras_n,
    input logic lcas_n,
    input logic ucas_n,
    input logic init_done,
    input logic err_flag
);
    int   since_rst, cas_run, ras_run, hi_run, wk_falls;
    logic ras_d, done_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 0;
            cas_run   <= 0;
            ras_run   <= 0;
            hi_run    <= 0;
            wk_falls  <= 0;
            ras_d     <= 1'b1;
            done_d    <= 1'b0;
        end else begin
            if (since_rst < PAUSE_CYC) since_rst <= since_rst + 1;
            cas_run <= !lcas_n ? cas_run + 1 : 0;
            ras_run <= !ras_n ? ras_run + 1 : 0;
            hi_run  <= (ras_n && lcas_n) ? hi_run + 1 : 0;
            ras_d   <= ras_n;
            done_d  <= init_done;
            if (done_d && !init_done) wk_falls <= 0;
            else if (ras_d && !ras_n) wk_falls <= wk_falls + 1;
        end
    end

    // R2: quiet bus during the power-up pause
    assert_pause_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst < PAUSE_CYC) |-> (ras_n && lcas_n && ucas_n && !ref_req));

    // R4: CAS low for the setup window before RAS falls
    assert_cas_setup_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!lcas_n && !ucas_n && cas_run >= CSR_CYC));

    // R4: CAS held past RAS fall and released while RAS is still low
    assert_cas_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(lcas_n) |-> (!ras_n && ras_run >= CHR_CYC));

    // R5: RAS pulse width
    assert_ras_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (ras_run >= RAS_CYC));

    // R5: precharge before the next CAS fall
    assert_precharge_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(lcas_n) |-> (hi_run >= PRE_CYC));

    // R3: ready only after the full set of wake-up cycles
    assert_wake_count_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (wk_falls >= WAKE_CYCLES));

    // R9: error flag is sticky
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R11: byte strobes move together
    assert_cas_pair_R11: assert property (@(posedge clk) disable iff (rst)
        (lcas_n == ucas_n));

endmodule

bind dram_refresh_sched refsched_chk #(
    .CSR_CYC    (CSR_CYC),
    .CHR_CYC    (CHR_CYC),
    .RAS_CYC    (RAS_CYC),
    .PRE_CYC    (PRE_CYC),
    .PAUSE_CYC  (PAUSE_CYC),
    .WAKE_CYCLES(WAKE_CYCLES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_req  (ref_req),
    .ras_n    (ras_n),
    .lcas_n   (lcas_n),
    .ucas_n   (ucas_n),
    .init_done(init_done),
    .err_flag (err_flag)
);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
    // expected cycle counts at 10 ns, rounded up by hand (R10)
    localparam int P    = 50;  // 500 ns
    localparam int REFI = 40;  // 395 ns
    localparam int CSR  = 2;   // 15 ns
    localparam int CHR  = 3;   // 25 ns
    localparam int RASW = 5;   // 45 ns, already above CHR+1
    localparam int PRE  = 4;   // max(35 ns, 10 ns)
    localparam int W    = 8;
    localparam int MAXP = 3;
    localparam int L    = CSR + RASW + PRE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gnt = 1'b1;
    logic ref_req, ras_n, lcas_n, ucas_n, init_done, err_flag;

    always #5 clk = ~clk;

    dram_refresh_sched #(
        .CLK_PS(10000), .PAUSE_NS(500), .REFI_NS(395), .CSR_NS(15), .CHR_NS(25),
        .RAS_NS(45), .RP_NS(35), .RPC_NS(10), .WAKE_CYCLES(W), .MAX_PEND(MAXP)
    ) i_dram_refresh_sched (
        .clk(clk), .rst(rst), .ref_gnt(gnt), .ref_req(ref_req), .ras_n(ras_n),
        .lcas_n(lcas_n), .ucas_n(ucas_n), .init_done(init_done), .err_flag(err_flag)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ph = 0, m_pcnt = 0, m_wake = 0, m_pend = 0, m_refi = 0, m_pos = -1;
    bit m_err = 0;
    bit edge_seen = 0;

    function automatic bit m_work();
        return (m_ph == 1 && m_wake > 0) || (m_ph == 2 && m_pend > 0);
    endfunction

    always @(posedge clk) begin
        edge_seen = 1;
        if (rst) begin
            m_ph = 0; m_pcnt = 0; m_wake = 0; m_pend = 0; m_refi = 0; m_pos = -1; m_err = 0;
        end else begin
            bit done, busy, start, tick;
            int npos, np;
            done  = (m_pos == L - 1);
            busy  = (m_pos >= 0);
            start = m_work() && gnt && !busy;
            tick  = (m_ph == 2) && (m_refi == REFI - 1);
            npos  = start ? 0 : ((busy && !done) ? m_pos + 1 : -1);
            if (m_ph == 0) begin
                if (m_pcnt == P - 1) begin m_ph = 1; m_wake = W; end
                else m_pcnt++;
            end else if (m_ph == 1) begin
                if (start) m_wake--;
                else if (done && m_wake == 0) begin m_ph = 2; m_refi = 0; m_pend = 0; end
            end else begin
                m_refi = tick ? 0 : m_refi + 1;
                np = m_pend + (tick ? 1 : 0) - (done ? 1 : 0);
                if (np < 0) np = 0;
                if (np > MAXP) begin
                    m_err = 1; m_ph = 1; m_wake = W; m_pend = 0; m_refi = 0;
                end else m_pend = np;
            end
            m_pos = npos;
        end
    end

    // ---------------- per-cycle compare and pulse monitor ----------------
    int cyc = 0, fall_cnt = 0, last_fall = 0;
    int cas_low_run = 0, ras_low_run = 0, high_run = 0;
    bit prev_ras = 1, prev_cas = 1;

    always @(negedge clk) begin
        if (edge_seen) begin
            bit e_ras, e_cas, e_req;
            e_ras = !(m_pos >= CSR && m_pos < CSR + RASW);
            e_cas = !(m_pos >= 0 && m_pos < CSR + CHR);
            e_req = (m_pos >= 0) || m_work();
            chk(ras_n == e_ras, "R4 R5 ras_n", ras_n, e_ras);
            chk(lcas_n == e_cas, "R4 lcas_n", lcas_n, e_cas);
            chk(ucas_n == lcas_n, "R11 ucas_n", ucas_n, lcas_n);
            chk(ref_req == e_req, "R7 ref_req", ref_req, e_req);
            chk(init_done == (m_ph == 2), "R3 init_done", init_done, m_ph == 2);
            chk(err_flag == m_err, "R9 err_flag", err_flag, m_err);
        end
        if (!rst && edge_seen) begin
            cyc++;
            if (prev_ras && !ras_n) begin
                chk(cas_low_run == CSR, "R4 cas setup", cas_low_run, CSR);
                fall_cnt++;
                last_fall = cyc;
            end
            if (!prev_ras && ras_n) chk(ras_low_run == RASW, "R5 ras width", ras_low_run, RASW);
            if (!prev_cas && lcas_n && !ras_n) chk(ras_low_run == CHR, "R4 cas hold", ras_low_run, CHR);
            if (prev_cas && !lcas_n) chk(high_run >= PRE, "R5 precharge", high_run, PRE);
            cas_low_run = !lcas_n ? cas_low_run + 1 : 0;
            ras_low_run = !ras_n ? ras_low_run + 1 : 0;
            high_run    = (ras_n && lcas_n) ? high_run + 1 : 0;
            prev_ras = ras_n;
            prev_cas = lcas_n;
        end
    end

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wait_fall();
        int c = fall_cnt;
        for (int i = 0; i < 2000 && fall_cnt == c; i++) @(posedge clk);
    endtask

    task automatic wait_req_low();
        @(negedge clk);
        for (int i = 0; i < 2000 && ref_req; i++) @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int n, t0, c;
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ras_n && lcas_n && ucas_n, "R1 strobes", {ras_n, lcas_n, ucas_n}, 7);
        chk(!ref_req && !init_done && !err_flag, "R1 flags", {ref_req, init_done, err_flag}, 0);
        rst = 1'b0;
        // R2 and R10: pause length in cycles
        n = 0;
        while (!ref_req && n < 1000) begin @(negedge clk); n++; end
        chk(n == P, "R2 R10 pause", n, P);
        // R3: wake-up count before ready
        @(posedge clk);
        c = fall_cnt;
        for (int i = 0; i < 2000 && !init_done; i++) @(posedge clk);
        chk(fall_cnt - c == W, "R3 wake count", fall_cnt - c, W);
        // R6: refresh spacing with the grant held
        wait_fall();
        for (int k = 0; k < 3; k++) begin
            t0 = last_fall;
            wait_fall();
            chk(last_fall - t0 == REFI, "R6 spacing", last_fall - t0, REFI);
        end
        // R7 and R8: withhold the grant for two intervals
        wait_req_low();
        gnt = 1'b0;
        repeat (70) @(negedge clk);
        chk(ref_req == 1'b1, "R7 req while owed", ref_req, 1);
        chk(ras_n && lcas_n, "R7 no strobe without grant", {ras_n, lcas_n}, 3);
        chk(err_flag == 1'b0, "R8 backlog no error", err_flag, 0);
        gnt = 1'b1;
        @(negedge clk);
        chk(lcas_n == 1'b0, "R7 start after grant", lcas_n, 0);
        @(posedge clk);
        c = fall_cnt;
        wait_req_low();
        @(posedge clk);
        chk(fall_cnt - c == 2, "R8 backlog burst", fall_cnt - c, 2);
        // R9: overflow and re-initialization
        wait_req_low();
        gnt = 1'b0;
        repeat (200) @(negedge clk);
        chk(err_flag == 1'b1, "R9 error set", err_flag, 1);
        chk(init_done == 1'b0, "R9 ready dropped", init_done, 0);
        @(posedge clk);
        c = fall_cnt;
        @(negedge clk);
        gnt = 1'b1;
        for (int i = 0; i < 2000 && !init_done; i++) @(posedge clk);
        chk(fall_cnt - c == W, "R9 rewake count", fall_cnt - c, W);
        chk(init_done == 1'b1, "R9 ready again", init_done, 1);
        // R7: grant toggled freely, including mid-sequence
        lfsr = 8'hA5;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            gnt = lfsr[0];
        end
        gnt = 1'b1;
        repeat (60) @(negedge clk);
        chk(err_flag == 1'b1, "R9 error still set", err_flag, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule